// File: doc/BRIEF.md
# Packet Buffer Allocator with Receive and Completion Queues

This block hands out packet buffers of a shared on-chip packet memory, each buffer named by a small packet number. A host issues an allocate command. The block picks the lowest-numbered buffer marked free in a bitmap, marks it used and publishes the number in an allocation result byte. It then raises an allocation-done bit. When nothing is free, the result shows a failure flag. The request then stays pending and is granted on its own once a buffer is returned.

The block also keeps two queues of packet numbers. The receive side pushes the numbers of arrived packets into a receive queue. The transmit side pushes the numbers of finished transmissions into a completion queue. One read-only 16-bit port shows the head of each queue next to that queue's empty flag. The host pops the receive head with dedicated commands: one only drops the head, the other drops it and frees its buffer. The host pops the completion head by acknowledging the transmit interrupt. A separate command frees the buffer whose number the host has written into a packet-number register.

Top module: `pba_alloc_top`

## Requirements
- R1: After reset every buffer is free, `allocResult` is 8'h00, `allocDone` is 0, both queues are empty (`fifoPorts[15]` and `fifoPorts[7]` are 1), and both overflow flags are 0.
- R2: Command code 1 (allocate), when any buffer is free, loads `allocResult` with bit 7 = 0 and bits 5:0 = the lowest-numbered free buffer, and sets `allocDone` at the same clock edge. That buffer is then no longer free.
- R3: Command code 1 with no free buffer loads `allocResult` with 8'h80 (bit 7 = failed) and leaves `allocDone` at 0. The request stays pending and is granted at the first clock edge at which a free buffer exists, which is the edge after the release.
- R4: `fifoPorts` bits 5:0 carry the completion-queue head and bit 7 is its empty flag. Bits 13:8 carry the receive-queue head and bit 15 is its empty flag. Bits 6 and 14 read 0. A head field is meaningful only while its empty flag is 0.
- R5: Command code 2 pops the receive head. Command code 3 pops the receive head and frees that buffer. Either code on an empty receive queue has no effect.
- R6: Command code 5 (transmit interrupt acknowledge) pops the completion-queue head. On an empty completion queue it has no effect, and it never touches the receive queue.
- R7: `rxIntStat` is 1 exactly when the receive queue is non-empty. `txIntStat` is 1 exactly when the completion queue is non-empty.
- R8: Command code 4 frees the buffer whose number was last written through `pnrWrEn`/`pnrWrData`.
- R9: Each queue holds 32 entries. A push that finds its queue full is dropped and sets that queue's overflow flag, which stays set until reset.
- R10: Each queue returns packet numbers in the order in which they were pushed.
- R11: A new allocate command clears `allocDone` unless the same edge grants a buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one command per cycle |
| cmdCode | input | 3 | 1 allocate, 2 pop receive, 3 pop receive and free, 4 free packet register, 5 acknowledge transmit; other codes do nothing |
| pnrWrEn | input | 1 | Write strobe for the packet-number register |
| pnrWrData | input | 6 | Packet number to be written |
| rxPushValid | input | 1 | Receive side pushes a packet number |
| rxPushNum | input | 6 | Packet number pushed into the receive queue |
| txPushValid | input | 1 | Transmit side pushes a completed packet number |
| txPushNum | input | 6 | Packet number pushed into the completion queue |
| allocResult | output | 8 | Bit 7 failed, bits 5:0 granted packet number |
| allocDone | output | 1 | Allocation-done interrupt bit |
| fifoPorts | output | 16 | Queue heads with their empty flags |
| rxIntStat | output | 1 | Receive queue non-empty |
| txIntStat | output | 1 | Completion queue non-empty |
| rxOverflow | output | 1 | Sticky: a receive push was dropped |
| txOverflow | output | 1 | Sticky: a completion push was dropped |

## Verification
On every cycle the assertions check the following. `allocDone` never rises together with a failed result, and a failed result never shows `allocDone` set. The unused port bits stay zero. The overflow flags never clear. An empty queue stays empty when nothing is pushed into it, however the pop commands are issued. The interrupt bits must also mirror the empty flags. Only the bench scenarios can show the choice of the lowest free number, the delayed grant after a release, first-in-first-out order, the dropping of the 33rd push and the return of buffers freed by the two release paths.

// File: rtl/pba_pkg.sv
package pba_pkg;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_ALLOC   = 3'd1,
    CMD_RX_DROP = 3'd2,
    CMD_RX_FREE = 3'd3,
    CMD_REL_PNR = 3'd4,
    CMD_TX_ACK  = 3'd5
  } cmd_e;

  // Strobes from the control to the datapath, all single-cycle.
  typedef struct packed {
    logic grant;
    logic failAlloc;
    logic rxPop;
    logic rxRelease;
    logic pnrRelease;
    logic txPop;
  } strobe_t;

endpackage

// File: rtl/pba_queue.sv
module pba_queue #(
  parameter int W     = 6,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pushValid,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             full, pushOk, popOk;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign pushOk = pushValid && !full;
  assign popOk  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pushValid && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/pba_ctrl.sv
module pba_ctrl
  import pba_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       anyFree,
  input  logic       rxEmpty,
  input  logic       txEmpty,
  output strobe_t    strobes,
  output logic       allocDone
);
  logic pending;
  logic allocReq;

  assign allocReq = cmdValid && (cmdCode == CMD_ALLOC);

  always_comb begin
    strobes            = '0;
    strobes.grant      = (allocReq || pending) && anyFree;
    strobes.failAlloc  = allocReq && !anyFree;
    strobes.rxPop      = cmdValid && !rxEmpty &&
                         ((cmdCode == CMD_RX_DROP) || (cmdCode == CMD_RX_FREE));
    strobes.rxRelease  = cmdValid && !rxEmpty && (cmdCode == CMD_RX_FREE);
    strobes.pnrRelease = cmdValid && (cmdCode == CMD_REL_PNR);
    strobes.txPop      = cmdValid && !txEmpty && (cmdCode == CMD_TX_ACK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      allocDone <= 1'b0;
    end else begin
      if (strobes.failAlloc)  pending <= 1'b1;
      else if (strobes.grant) pending <= 1'b0;

      if (strobes.grant)  allocDone <= 1'b1;
      else if (allocReq)  allocDone <= 1'b0;
    end
  end
endmodule

// File: rtl/pba_datapath.sv
module pba_datapath
  import pba_pkg::*;
#(
  parameter int PNUM_W   = 6,
  parameter int NUM_BUFS = 64,
  parameter int QDEPTH   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              pnrWrEn,
  input  logic [PNUM_W-1:0] pnrWrData,
  input  logic              rxPushValid,
  input  logic [PNUM_W-1:0] rxPushNum,
  input  logic              txPushValid,
  input  logic [PNUM_W-1:0] txPushNum,
  output logic              anyFree,
  output logic [7:0]        allocResult,
  output logic [PNUM_W-1:0] rxHead,
  output logic              rxEmpty,
  output logic              rxOverflow,
  output logic [PNUM_W-1:0] txHead,
  output logic              txEmpty,
  output logic              txOverflow
);
  localparam int FAIL_BIT = 7;

  logic [NUM_BUFS-1:0] freeMap, freeNext;
  logic [PNUM_W-1:0]   grantNum, relNum, pnrReg;
  logic                relEn;

  // Lowest-numbered free buffer.
  always_comb begin
    grantNum = '0;
    for (int i = NUM_BUFS - 1; i >= 0; i--) begin
      if (freeMap[i]) grantNum = PNUM_W'(i);
    end
  end

  assign anyFree = |freeMap;
  assign relEn   = strobes.rxRelease || strobes.pnrRelease;
  assign relNum  = strobes.rxRelease ? rxHead : pnrReg;

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_bit
    always_comb begin
      freeNext[b] = (freeMap[b] || (relEn && relNum == PNUM_W'(b))) &&
                    !(strobes.grant && grantNum == PNUM_W'(b));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeMap     <= '1;
      allocResult <= '0;
      pnrReg      <= '0;
    end else begin
      freeMap <= freeNext;
      if (pnrWrEn) pnrReg <= pnrWrData;
      if (strobes.grant) begin
        allocResult              <= '0;
        allocResult[PNUM_W-1:0]  <= grantNum;
      end else if (strobes.failAlloc) begin
        allocResult              <= '0;
        allocResult[FAIL_BIT]    <= 1'b1;
      end
    end
  end

  pba_queue #(.W(PNUM_W), .DEPTH(QDEPTH)) rxQ_i (
    .clk(clk), .rstN(rstN),
    .pushValid(rxPushValid), .pushData(rxPushNum),
    .pop(strobes.rxPop),
    .head(rxHead), .empty(rxEmpty), .overflow(rxOverflow)
  );

  pba_queue #(.W(PNUM_W), .DEPTH(QDEPTH)) txQ_i (
    .clk(clk), .rstN(rstN),
    .pushValid(txPushValid), .pushData(txPushNum),
    .pop(strobes.txPop),
    .head(txHead), .empty(txEmpty), .overflow(txOverflow)
  );
endmodule

// File: rtl/pba_alloc_top.sv
module pba_alloc_top
  import pba_pkg::*;
#(
  parameter int PNUM_W   = 6,
  parameter int NUM_BUFS = 64,
  parameter int QDEPTH   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdCode,
  input  logic              pnrWrEn,
  input  logic [PNUM_W-1:0] pnrWrData,
  input  logic              rxPushValid,
  input  logic [PNUM_W-1:0] rxPushNum,
  input  logic              txPushValid,
  input  logic [PNUM_W-1:0] txPushNum,
  output logic [7:0]        allocResult,
  output logic              allocDone,
  output logic [15:0]       fifoPorts,
  output logic              rxIntStat,
  output logic              txIntStat,
  output logic              rxOverflow,
  output logic              txOverflow
);
  strobe_t           strobes;
  logic              anyFree, rxEmpty, txEmpty;
  logic [PNUM_W-1:0] rxHead, txHead;

  pba_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdCode(cmdCode),
    .anyFree(anyFree), .rxEmpty(rxEmpty), .txEmpty(txEmpty),
    .strobes(strobes), .allocDone(allocDone)
  );

  pba_datapath #(.PNUM_W(PNUM_W), .NUM_BUFS(NUM_BUFS), .QDEPTH(QDEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pnrWrEn(pnrWrEn), .pnrWrData(pnrWrData),
    .rxPushValid(rxPushValid), .rxPushNum(rxPushNum),
    .txPushValid(txPushValid), .txPushNum(txPushNum),
    .anyFree(anyFree), .allocResult(allocResult),
    .rxHead(rxHead), .rxEmpty(rxEmpty), .rxOverflow(rxOverflow),
    .txHead(txHead), .txEmpty(txEmpty), .txOverflow(txOverflow)
  );

  always_comb begin
    fifoPorts                 = '0;
    fifoPorts[PNUM_W-1:0]     = txHead;
    fifoPorts[7]              = txEmpty;
    fifoPorts[8 +: PNUM_W]    = rxHead;
    fifoPorts[15]             = rxEmpty;
  end

  assign rxIntStat = !rxEmpty;
  assign txIntStat = !txEmpty;
endmodule

// File: rtl/pba_alloc_chk.sv
module pba_alloc_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rxPushValid,
  input logic        txPushValid,
  input logic [7:0]  allocResult,
  input logic        allocDone,
  input logic [15:0] fifoPorts,
  input logic        rxIntStat,
  input logic        txIntStat,
  input logic        rxOverflow,
  input logic        txOverflow
);
  p_done_clean_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(allocDone) |-> !allocResult[7]);

  p_fail_no_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    allocResult[7] |-> !allocDone);

  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !fifoPorts[6] && !fifoPorts[14]);

  p_rx_empty_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fifoPorts[15] && !rxPushValid) |=> fifoPorts[15]);

  p_tx_empty_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fifoPorts[7] && !txPushValid) |=> fifoPorts[7]);

  p_int_mirror_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxIntStat == !fifoPorts[15]) && (txIntStat == !fifoPorts[7]));

  p_no_overflow_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverflow |=> rxOverflow) and (txOverflow |=> txOverflow));
endmodule

bind pba_alloc_top pba_alloc_chk chk_i (
  .clk(clk), .rstN(rstN),
  .rxPushValid(rxPushValid), .txPushValid(txPushValid),
  .allocResult(allocResult), .allocDone(allocDone),
  .fifoPorts(fifoPorts), .rxIntStat(rxIntStat), .txIntStat(txIntStat),
  .rxOverflow(rxOverflow), .txOverflow(txOverflow)
);

// File: tb/pba_alloc_top_tb_top.sv
`timescale 1ns/1ps
module pba_alloc_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdCode = '0;
  logic        pnrWrEn = 1'b0;
  logic [5:0]  pnrWrData = '0;
  logic        rxPushValid = 1'b0;
  logic [5:0]  rxPushNum = '0;
  logic        txPushValid = 1'b0;
  logic [5:0]  txPushNum = '0;
  logic [7:0]  allocResult;
  logic        allocDone;
  logic [15:0] fifoPorts;
  logic        rxIntStat, txIntStat, rxOverflow, txOverflow;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pba_alloc_top dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .pnrWrEn(pnrWrEn), .pnrWrData(pnrWrData),
    .rxPushValid(rxPushValid), .rxPushNum(rxPushNum),
    .txPushValid(txPushValid), .txPushNum(txPushNum),
    .allocResult(allocResult), .allocDone(allocDone), .fifoPorts(fifoPorts),
    .rxIntStat(rxIntStat), .txIntStat(txIntStat),
    .rxOverflow(rxOverflow), .txOverflow(txOverflow)
  );

  // Vector: {command, packet register value, expected allocResult}
  localparam logic [16:0] VEC [8] = '{
    {3'd1, 6'd0, 8'h00},
    {3'd1, 6'd0, 8'h01},
    {3'd1, 6'd0, 8'h02},
    {3'd4, 6'd1, 8'h02},
    {3'd1, 6'd0, 8'h01},
    {3'd1, 6'd0, 8'h03},
    {3'd4, 6'd0, 8'h03},
    {3'd1, 6'd0, 8'h00}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [2:0] c);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdCode  = c;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdCode  = '0;
  endtask

  task automatic writePnr(input logic [5:0] n);
    @(negedge clk);
    pnrWrEn   = 1'b1;
    pnrWrData = n;
    @(negedge clk);
    pnrWrEn   = 1'b0;
  endtask

  task automatic pushRx(input logic [5:0] n);
    @(negedge clk);
    rxPushValid = 1'b1;
    rxPushNum   = n;
    @(negedge clk);
    rxPushValid = 1'b0;
  endtask

  task automatic pushTx(input logic [5:0] n);
    @(negedge clk);
    txPushValid = 1'b1;
    txPushNum   = n;
    @(negedge clk);
    txPushValid = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 result", {8'h0, allocResult}, 16'h0000);
    check("R1 done", {15'h0, allocDone}, 16'h0000);
    check("R1 empty flags", fifoPorts & 16'h8080, 16'h8080);
    check("R1 overflow", {14'h0, rxOverflow, txOverflow}, 16'h0000);
    check("R7 reset ints", {14'h0, rxIntStat, txIntStat}, 16'h0000);

    // Vector walk: R2 lowest free number, R8 release through packet register
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][16:14] == 3'd4) writePnr(VEC[i][13:8]);
      doCmd(VEC[i][16:14]);
      check("R2/R8 vector result", {8'h0, allocResult}, {8'h0, VEC[i][7:0]});
    end
    check("R2 done after grant", {15'h0, allocDone}, 16'h0001);

    // Exhaust the pool: buffers 0..3 are in use.
    for (int k = 4; k < 64; k++) begin
      doCmd(3'd1);
      check("R2 exhaust", {8'h0, allocResult}, 16'(k));
    end

    // R3 failure, R11 done cleared by the new command
    doCmd(3'd1);
    check("R3 failed result", {8'h0, allocResult}, 16'h0080);
    check("R11 done cleared", {15'h0, allocDone}, 16'h0000);
    writePnr(6'd10);
    doCmd(3'd4);
    check("R3 not yet granted", {8'h0, allocResult}, 16'h0080);
    check("R3 done still low", {15'h0, allocDone}, 16'h0000);
    @(negedge clk);
    check("R3 pending grant", {8'h0, allocResult}, 16'h000A);
    check("R3 done raised", {15'h0, allocDone}, 16'h0001);

    // Receive queue: R4 layout, R5 pops, R7 interrupt bit, R10 order
    pushRx(6'd5);
    pushRx(6'd9);
    check("R4 rx head", fifoPorts & 16'hFF80, 16'h0580);
    check("R4 pad bits", fifoPorts & 16'h4040, 16'h0000);
    check("R7 rx int", {15'h0, rxIntStat}, 16'h0001);
    doCmd(3'd2);
    check("R10 rx second entry", fifoPorts & 16'hFF80, 16'h0980);
    doCmd(3'd3);
    check("R5 rx empty after pops", fifoPorts & 16'h8080, 16'h8080);
    check("R7 rx int low", {15'h0, rxIntStat}, 16'h0000);
    doCmd(3'd1);
    check("R5 freed by pop-and-free", {8'h0, allocResult}, 16'h0009);
    doCmd(3'd3);
    doCmd(3'd2);
    check("R5 pop on empty ignored", fifoPorts & 16'h8080, 16'h8080);
    doCmd(3'd1);
    check("R5 empty pop freed nothing", {8'h0, allocResult}, 16'h0080);
    writePnr(6'd20);
    doCmd(3'd4);
    @(negedge clk);
    check("R8 pnr release regrants", {8'h0, allocResult}, 16'h0014);

    // Completion queue: R6, R7
    pushTx(6'd7);
    pushTx(6'd3);
    check("R4 tx head", fifoPorts & 16'h00FF, 16'h0007);
    check("R7 tx int", {15'h0, txIntStat}, 16'h0001);
    doCmd(3'd5);
    check("R6 tx next head", fifoPorts & 16'h00FF, 16'h0003);
    check("R6 rx untouched", fifoPorts & 16'h8000, 16'h8000);
    doCmd(3'd5);
    check("R6 tx empty", fifoPorts & 16'h0080, 16'h0080);
    doCmd(3'd5);
    check("R6 ack on empty ignored", fifoPorts & 16'h8080, 16'h8080);
    check("R7 tx int low", {15'h0, txIntStat}, 16'h0000);

    // R9 overflow, R10 order over a full queue
    for (int n = 0; n < 33; n++) pushRx(6'(n + 16));
    check("R9 rx overflow set", {15'h0, rxOverflow}, 16'h0001);
    check("R9 tx overflow clear", {15'h0, txOverflow}, 16'h0000);
    for (int n = 0; n < 32; n++) begin
      check("R10 rx order", {10'h0, fifoPorts[13:8]}, 16'(n + 16));
      doCmd(3'd2);
    end
    check("R9 33rd push dropped", fifoPorts & 16'h8000, 16'h8000);
    check("R9 overflow sticky", {15'h0, rxOverflow}, 16'h0001);

    finish();
  end
endmodule